// File: doc/BRIEF.md
# Stack Limit Check Unit

This unit watches each decoded load or store and decides whether it breaks a stack bound. An access counts as a stack access only when general register R1 is its base or its index register, and when the operation does not use R1 to carry a decoration value. Each of the comparator slots holds a 32-bit bound and a direction. The overflow direction flags addresses below the bound, and the underflow direction flags addresses above it. For a misaligned access, both address halves are tested.

The effect of a violation depends on who owns the slot. A software-owned slot blocks the access in the same cycle and raises an exception one cycle later. The exception type follows the privilege mode: machine check for supervisor accesses and data-storage for user accesses. The address of the offending instruction is captured with the exception. A hardware-owned slot lets the access complete and raises a debug status flag, the same way an ordinary data-address match does. If another exception kills the access, a separate pulse marks the instruction as not completed. A watchpoint pulse is emitted for each hitting slot under either kind of ownership.

Top module: `stklim_unit`

## Requirements
- R1: A slot can hit only while `acc_valid` is 1 and at least one of `acc_r1_base` or `acc_r1_index` is 1.
- R2: When `acc_decorated` is 1, no slot hits, whatever the addresses and configuration.
- R3: A slot takes part in checking only when its 4-bit mode field equals 4'b1000. Any other value disables it.
- R4: A 2-bit privilege field selects the modes that are checked. A supervisor access (`acc_super`=1) is checked for values 2'b00 and 2'b10. A user access is checked for values 2'b00 and 2'b01. The value 2'b11 checks neither mode.
- R5: The direction bit selects the compare against the bound, both treated as unsigned. With direction 0, an address below the bound hits. With direction 1, an address above the bound hits. An address equal to the bound never hits.
- R6: `acc_addr0` is always compared. `acc_addr1` is compared only when `acc_split` is 1. A hit on either address is a hit for the slot.
- R7: `abort_req` is 1 in the same cycle as the access exactly when a slot whose ownership bit is 0 (software-owned) hits.
- R8: In the cycle after a software-owned hit, the unit does three things for one cycle:
  - pulses `mchk_req` if the access was supervisor, or `dsi_req` if it was user;
  - holds `exc_pc` at the `acc_pc` of that access;
  - sets no debug flag.
- R9: In the cycle after any hit, bit i of `wpt_pulse` is 1 for each slot i that hit, under either ownership.
- R10: If no software-owned slot hits, then bit i of `dbg_flag_set` pulses in the next cycle for each hardware-owned slot i that hit. `abort_req` stays 0 in that case.
- R11: `dbg_incomplete` pulses in the next cycle when R10 sets a flag and `acc_other_abort` was 1 for that access.
- R12: While `rst` is high, and in the first cycle after it falls, all registered outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | A load/store is presented this cycle |
| acc_addr0 | input | AW | Effective address of the first (or only) half |
| acc_addr1 | input | AW | Address of the second half of a misaligned access |
| acc_split | input | 1 | Access is misaligned and has two halves |
| acc_pc | input | AW | Address of the load/store instruction |
| acc_super | input | 1 | 1 for supervisor, 0 for user privilege |
| acc_r1_base | input | 1 | R1 is the base register |
| acc_r1_index | input | 1 | R1 is the index register |
| acc_decorated | input | 1 | Decorated operation; R1 holds a decoration value |
| acc_other_abort | input | 1 | Access is being killed by an unrelated exception |
| cfg_mode | input | 4*NCMP | Per-slot mode field; 4'b1000 selects stack checking |
| cfg_priv | input | 2*NCMP | Per-slot privilege select |
| cfg_dir | input | NCMP | Per-slot direction: 0 below bound, 1 above bound |
| cfg_hw_own | input | NCMP | Per-slot ownership: 1 hardware/debugger, 0 software |
| cfg_limit | input | AW*NCMP | Per-slot bound address |
| abort_req | output | 1 | Block the access (combinational) |
| mchk_req | output | 1 | Machine-check request pulse |
| dsi_req | output | 1 | Data-storage exception request pulse |
| exc_pc | output | AW | Captured instruction address for the exception |
| wpt_pulse | output | NCMP | Per-slot watchpoint pulse |
| dbg_flag_set | output | NCMP | Per-slot debug status flag set pulse |
| dbg_incomplete | output | 1 | Flagged access did not complete |

## Verification
The checker assumes that `acc_addr1` and `acc_split` are coherent with the current access and that the configuration buses are stable while an access is checked. It also assumes that `acc_pc` is sampled only in the cycle of the access. The bench drives every field on the falling edge, holds the configuration fixed across each access, and gives each access its own `acc_pc`. This keeps the one-cycle relations between `abort_req` and the registered pulses meaningful. The address patterns straddle and touch each bound so that both compare directions, the equal case and the split halves are all covered.

// File: rtl/stklim_pkg.sv
`timescale 1ns/1ps
package stklim_pkg;
  localparam logic [3:0] MODE_STACK = 4'b1000;

  typedef enum logic [1:0] {
    PSEL_ANY  = 2'b00,
    PSEL_USER = 2'b01,
    PSEL_SUPV = 2'b10,
    PSEL_NONE = 2'b11
  } psel_e;

  function automatic logic priv_allows(input logic [1:0] psel, input logic sup);
    if (sup) return (psel == PSEL_ANY) || (psel == PSEL_SUPV);
    else     return (psel == PSEL_ANY) || (psel == PSEL_USER);
  endfunction
endpackage

// File: rtl/stklim_cmp.sv
`timescale 1ns/1ps
module stklim_cmp
  import stklim_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          elig,
  input  logic          sup,
  input  logic          split,
  input  logic [3:0]    mode,
  input  logic [1:0]    priv,
  input  logic          dir,
  input  logic [AW-1:0] limit,
  input  logic [AW-1:0] addr0,
  input  logic [AW-1:0] addr1,
  output logic          hit
);
  logic armed, past0, past1;

  // dir 0: overflow (below bound); dir 1: underflow (above bound)
  always_comb begin
    armed = elig && (mode == MODE_STACK) && priv_allows(priv, sup);
    past0 = dir ? (addr0 > limit) : (addr0 < limit);
    past1 = split && (dir ? (addr1 > limit) : (addr1 < limit));
    hit   = armed && (past0 || past1);
  end
endmodule

// File: rtl/stklim_resp.sv
`timescale 1ns/1ps
module stklim_resp #(
  parameter int NCMP = 2,
  parameter int AW   = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NCMP-1:0] hit,
  input  logic [NCMP-1:0] hw_own,
  input  logic            sup,
  input  logic            other_abort,
  input  logic [AW-1:0]   pc,
  output logic            abort_req,
  output logic            mchk_req,
  output logic            dsi_req,
  output logic [AW-1:0]   exc_pc,
  output logic [NCMP-1:0] wpt_pulse,
  output logic [NCMP-1:0] dbg_flag_set,
  output logic            dbg_incomplete
);
  logic            sw_hit;
  logic [NCMP-1:0] hw_hits;

  always_comb begin
    sw_hit    = |(hit & ~hw_own);
    hw_hits   = sw_hit ? '0 : (hit & hw_own);
    abort_req = sw_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mchk_req       <= 1'b0;
      dsi_req        <= 1'b0;
      exc_pc         <= '0;
      wpt_pulse      <= '0;
      dbg_flag_set   <= '0;
      dbg_incomplete <= 1'b0;
    end else begin
      mchk_req       <= sw_hit && sup;
      dsi_req        <= sw_hit && !sup;
      if (sw_hit) exc_pc <= pc;
      wpt_pulse      <= hit;
      dbg_flag_set   <= hw_hits;
      dbg_incomplete <= (|hw_hits) && other_abort;
    end
  end
endmodule

// File: rtl/stklim_unit.sv
`timescale 1ns/1ps
module stklim_unit #(
  parameter int NCMP = 2,
  parameter int AW   = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_valid,
  input  logic [AW-1:0]    acc_addr0,
  input  logic [AW-1:0]    acc_addr1,
  input  logic             acc_split,
  input  logic [AW-1:0]    acc_pc,
  input  logic             acc_super,
  input  logic             acc_r1_base,
  input  logic             acc_r1_index,
  input  logic             acc_decorated,
  input  logic             acc_other_abort,
  input  logic [4*NCMP-1:0]  cfg_mode,
  input  logic [2*NCMP-1:0]  cfg_priv,
  input  logic [NCMP-1:0]    cfg_dir,
  input  logic [NCMP-1:0]    cfg_hw_own,
  input  logic [AW*NCMP-1:0] cfg_limit,
  output logic             abort_req,
  output logic             mchk_req,
  output logic             dsi_req,
  output logic [AW-1:0]    exc_pc,
  output logic [NCMP-1:0]  wpt_pulse,
  output logic [NCMP-1:0]  dbg_flag_set,
  output logic             dbg_incomplete
);
  logic            elig;
  logic [NCMP-1:0] hit;

  assign elig = acc_valid && (acc_r1_base || acc_r1_index) && !acc_decorated;

  for (genvar g = 0; g < NCMP; g++) begin : g_slot
    stklim_cmp #(.AW(AW)) u_cmp (
      .elig  (elig),
      .sup   (acc_super),
      .split (acc_split),
      .mode  (cfg_mode[4*g +: 4]),
      .priv  (cfg_priv[2*g +: 2]),
      .dir   (cfg_dir[g]),
      .limit (cfg_limit[AW*g +: AW]),
      .addr0 (acc_addr0),
      .addr1 (acc_addr1),
      .hit   (hit[g])
    );
  end

  stklim_resp #(.NCMP(NCMP), .AW(AW)) u_resp (
    .clk            (clk),
    .rst            (rst),
    .hit            (hit),
    .hw_own         (cfg_hw_own),
    .sup            (acc_super),
    .other_abort    (acc_other_abort),
    .pc             (acc_pc),
    .abort_req      (abort_req),
    .mchk_req       (mchk_req),
    .dsi_req        (dsi_req),
    .exc_pc         (exc_pc),
    .wpt_pulse      (wpt_pulse),
    .dbg_flag_set   (dbg_flag_set),
    .dbg_incomplete (dbg_incomplete)
  );
endmodule

// File: rtl/stklim_chk.sv
`timescale 1ns/1ps
module stklim_chk #(
  parameter int NCMP = 2,
  parameter int AW   = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             acc_valid,
  input logic             acc_super,
  input logic             acc_r1_base,
  input logic             acc_r1_index,
  input logic             acc_decorated,
  input logic [AW-1:0]    acc_pc,
  input logic [4*NCMP-1:0] cfg_mode,
  input logic             abort_req,
  input logic             mchk_req,
  input logic             dsi_req,
  input logic [AW-1:0]    exc_pc,
  input logic [NCMP-1:0]  wpt_pulse,
  input logic [NCMP-1:0]  dbg_flag_set,
  input logic             dbg_incomplete
);
  logic any_stack_mode;
  always_comb begin
    any_stack_mode = 1'b0;
    for (int i = 0; i < NCMP; i++)
      if (cfg_mode[4*i +: 4] == 4'b1000) any_stack_mode = 1'b1;
  end

  p_abort_needs_r1_r1: assert property (@(posedge clk) disable iff (rst)
    abort_req |-> (acc_valid && (acc_r1_base || acc_r1_index)));
  p_no_abort_decorated_r2: assert property (@(posedge clk) disable iff (rst)
    acc_decorated |-> !abort_req);
  p_abort_needs_mode_r3: assert property (@(posedge clk) disable iff (rst)
    abort_req |-> any_stack_mode);
  p_mchk_follows_r8: assert property (@(posedge clk) disable iff (rst)
    (abort_req && acc_super) |=> (mchk_req && !dsi_req));
  p_dsi_follows_r8: assert property (@(posedge clk) disable iff (rst)
    (abort_req && !acc_super) |=> (dsi_req && !mchk_req));
  p_pc_capture_r8: assert property (@(posedge clk) disable iff (rst)
    abort_req |=> (exc_pc == $past(acc_pc)));
  p_no_flag_on_exc_r10: assert property (@(posedge clk) disable iff (rst)
    (mchk_req || dsi_req) |-> (dbg_flag_set == '0));
  p_flag_has_wpt_r9: assert property (@(posedge clk) disable iff (rst)
    (dbg_flag_set & ~wpt_pulse) == '0);
  p_incomplete_flag_r11: assert property (@(posedge clk) disable iff (rst)
    dbg_incomplete |-> (dbg_flag_set != '0));
endmodule

bind stklim_unit stklim_chk #(.NCMP(NCMP), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_super(acc_super),
  .acc_r1_base(acc_r1_base), .acc_r1_index(acc_r1_index),
  .acc_decorated(acc_decorated), .acc_pc(acc_pc), .cfg_mode(cfg_mode),
  .abort_req(abort_req), .mchk_req(mchk_req), .dsi_req(dsi_req),
  .exc_pc(exc_pc), .wpt_pulse(wpt_pulse), .dbg_flag_set(dbg_flag_set),
  .dbg_incomplete(dbg_incomplete)
);

// File: tb/stklim_unit_tb_top.sv
`timescale 1ns/1ps
module stklim_unit_tb_top;
  localparam int AW = 32;
  localparam int NCMP = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst;
  logic acc_valid, acc_split, acc_super, acc_r1_base, acc_r1_index, acc_decorated, acc_other_abort;
  logic [AW-1:0] acc_addr0, acc_addr1, acc_pc;
  logic [3:0] md0, md1;
  logic [1:0] pv0, pv1;
  logic dr0, dr1, ow0, ow1;
  logic [AW-1:0] lm0, lm1;
  logic abort_req, mchk_req, dsi_req, dbg_incomplete;
  logic [AW-1:0] exc_pc;
  logic [NCMP-1:0] wpt_pulse, dbg_flag_set;

  stklim_unit #(.NCMP(NCMP), .AW(AW)) dut_i (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr0(acc_addr0),
    .acc_addr1(acc_addr1), .acc_split(acc_split), .acc_pc(acc_pc),
    .acc_super(acc_super), .acc_r1_base(acc_r1_base), .acc_r1_index(acc_r1_index),
    .acc_decorated(acc_decorated), .acc_other_abort(acc_other_abort),
    .cfg_mode({md1, md0}), .cfg_priv({pv1, pv0}), .cfg_dir({dr1, dr0}),
    .cfg_hw_own({ow1, ow0}), .cfg_limit({lm1, lm0}),
    .abort_req(abort_req), .mchk_req(mchk_req), .dsi_req(dsi_req),
    .exc_pc(exc_pc), .wpt_pulse(wpt_pulse), .dbg_flag_set(dbg_flag_set),
    .dbg_incomplete(dbg_incomplete)
  );

  int nchk = 0, nerr = 0;
  bit done = 0;
  logic [AW-1:0] pc_ctr = 32'h0000_4000;

  task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // Reference: a slot hits per R1..R6
  function automatic logic ref_hit(input logic [3:0] m, input logic [1:0] p, input logic d,
      input logic [AW-1:0] lim, input logic [AW-1:0] a0, input logic [AW-1:0] a1,
      input logic v, input logic sp, input logic sup, input logic rb, input logic ri, input logic dec);
    logic on, c0, c1;
    on = v && (rb || ri) && !dec && (m == 4'b1000) &&
         (sup ? (p == 2'b00 || p == 2'b10) : (p == 2'b00 || p == 2'b01));
    c0 = d ? (a0 > lim) : (a0 < lim);
    c1 = sp && (d ? (a1 > lim) : (a1 < lim));
    return on && (c0 || c1);
  endfunction

  task automatic step(input string tag, input logic [AW-1:0] a0, input logic [AW-1:0] a1,
      input logic sp, input logic sup, input logic rb, input logic ri, input logic dec, input logic oab);
    logic h0, h1, swh;
    logic [1:0] hv, fl;
    logic [AW-1:0] pcv;
    @(negedge clk);
    pc_ctr += 4;
    pcv = pc_ctr;
    acc_addr0 = a0; acc_addr1 = a1; acc_split = sp; acc_super = sup;
    acc_r1_base = rb; acc_r1_index = ri; acc_decorated = dec; acc_other_abort = oab;
    acc_pc = pcv;
    h0 = ref_hit(md0, pv0, dr0, lm0, a0, a1, acc_valid, sp, sup, rb, ri, dec);
    h1 = ref_hit(md1, pv1, dr1, lm1, a0, a1, acc_valid, sp, sup, rb, ri, dec);
    hv = {h1, h0};
    swh = (h0 && !ow0) || (h1 && !ow1);
    fl = swh ? 2'b00 : (hv & {ow1, ow0});
    #1;
    check({tag, " R7 abort_req"}, 64'(abort_req), 64'(swh));
    @(posedge clk);
    #1;
    check({tag, " R8 mchk_req"}, 64'(mchk_req), 64'(swh && sup));
    check({tag, " R8 dsi_req"}, 64'(dsi_req), 64'(swh && !sup));
    if (swh) check({tag, " R8 exc_pc"}, 64'(exc_pc), 64'(pcv));
    check({tag, " R9 wpt_pulse"}, 64'(wpt_pulse), 64'(hv));
    check({tag, " R10 dbg_flag_set"}, 64'(dbg_flag_set), 64'(fl));
    check({tag, " R11 dbg_incomplete"}, 64'(dbg_incomplete), 64'((fl != 0) && oab));
  endtask

  function automatic logic [AW-1:0] pat0(input int k);
    case (k)
      0: return 32'h0000_0FFC;
      1: return 32'h0000_1000;
      default: return 32'h0000_0FF0;
    endcase
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; acc_valid = 1'b1; acc_split = 0; acc_super = 0; acc_r1_base = 1;
    acc_r1_index = 0; acc_decorated = 0; acc_other_abort = 0;
    acc_addr0 = 32'h0; acc_addr1 = 32'h0; acc_pc = 32'h0;
    md0 = 4'b1000; md1 = 4'b1000; pv0 = 0; pv1 = 0; dr0 = 0; dr1 = 0; ow0 = 0; ow1 = 0;
    lm0 = 32'h1000; lm1 = 32'h1000;
    repeat (3) @(negedge clk);
    // R12: registered outputs cleared while reset is held
    check("R12 mchk_req", 64'(mchk_req), 0);
    check("R12 dsi_req", 64'(dsi_req), 0);
    check("R12 wpt_pulse", 64'(wpt_pulse), 0);
    check("R12 dbg_flag_set", 64'(dbg_flag_set), 0);
    check("R12 dbg_incomplete", 64'(dbg_incomplete), 0);
    check("R12 exc_pc", 64'(exc_pc), 0);
    rst = 1'b0;

    // Directed cases, slot 1 disabled
    md1 = 4'b0000;
    md0 = 4'b1000; pv0 = 2'b00; dr0 = 0; ow0 = 0;
    step("R1 no-R1-register", 32'h0FFC, 32'h1000, 0, 1, 0, 0, 0, 0);
    acc_valid = 1'b0;
    step("R1 invalid", 32'h0FFC, 32'h1000, 0, 1, 1, 0, 0, 0);
    acc_valid = 1'b1;
    step("R1 index-only", 32'h0FFC, 32'h1000, 0, 0, 0, 1, 0, 0);
    step("R2 decorated", 32'h0FFC, 32'h1000, 0, 1, 1, 1, 1, 0);
    md0 = 4'b1001;
    step("R3 wrong-mode", 32'h0FFC, 32'h1000, 0, 1, 1, 0, 0, 0);
    md0 = 4'b1000; pv0 = 2'b01;
    step("R4 user-only-vs-super", 32'h0FFC, 32'h1000, 0, 1, 1, 0, 0, 0);
    pv0 = 2'b11;
    step("R4 none", 32'h0FFC, 32'h1000, 0, 0, 1, 0, 0, 0);
    pv0 = 2'b00; dr0 = 1;
    step("R5 equal-bound", 32'h1000, 32'h1000, 1, 1, 1, 0, 0, 0);
    step("R6 second-half", 32'h1000, 32'h1004, 1, 0, 1, 0, 0, 0);
    step("R6 no-split", 32'h1000, 32'h1004, 0, 0, 1, 0, 0, 0);
    ow0 = 1;
    step("R11 hw-other-abort", 32'h1004, 32'h1008, 0, 1, 1, 0, 0, 1);

    // Sweep A: one slot, all field combinations
    for (int m = 0; m < 2; m++)
      for (int p = 0; p < 4; p++)
        for (int o = 0; o < 2; o++)
          for (int d = 0; d < 2; d++) begin
            md0 = m ? 4'b1001 : 4'b1000; pv0 = 2'(p); ow0 = 1'(o); dr0 = 1'(d);
            for (int s = 0; s < 2; s++)
              for (int r = 0; r < 4; r++)
                for (int dc = 0; dc < 2; dc++)
                  for (int sp = 0; sp < 2; sp++)
                    for (int k = 0; k < 3; k++)
                      for (int oa = 0; oa < 2; oa++)
                        step("SWEEP-A", pat0(k), pat0(k) + 4, 1'(sp), 1'(s),
                             1'(r & 1), 1'(r >> 1), 1'(dc), 1'(oa));
          end

    // Sweep B: both slots active, mixed ownership and directions
    md0 = 4'b1000; md1 = 4'b1000; pv0 = 2'b00; pv1 = 2'b00;
    for (int o = 0; o < 4; o++)
      for (int d = 0; d < 4; d++) begin
        ow0 = 1'(o); ow1 = 1'(o >> 1); dr0 = 1'(d); dr1 = 1'(d >> 1);
        for (int s = 0; s < 2; s++)
          for (int sp = 0; sp < 2; sp++)
            for (int k = 0; k < 3; k++)
              for (int oa = 0; oa < 2; oa++)
                step("SWEEP-B", pat0(k), pat0(k) + 4, 1'(sp), 1'(s), 1, 0, 0, 1'(oa));
      end

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule